// File: doc/BRIEF.md
# Isochronous Cycle Time Counter

This block keeps bus time for an isochronous link. It counts edges of a 24.576 MHz tick enable and holds the result as one 32-bit word made of three cascaded fields: a sub-cycle offset, a cycle number and a seconds value. The offset counts ticks within one 125 us cycle. The cycle number counts cycles within one second. The seconds field counts seconds and wraps freely.

Software or a neighbouring block can overwrite the whole word in one clock with a synchronous load. A read strobe captures a snapshot of the word into a registered read port. The same strobe also captures a linear tick count made from that word, so two snapshots can be compared by plain subtraction. The live word is always visible as a registered output.

Top module: `ctime_counter`

## Requirements
- R1: While `rst` is high, `time_word`, `rd_word` and `rd_ticks` are all zero after the next clock edge.
- R2: The word holds seconds in bits [31:25], cycle number in bits [24:12] and offset in bits [11:0]. With `tick_en` high and `load_en` low, the offset rises by one per clock. With both low, the word does not change.
- R3: An offset of 3071 with a tick becomes 0 on the same edge that the cycle number rises by one.
- R4: A cycle number of 7999 at an offset wrap becomes 0 on the same edge that the seconds field rises by one.
- R5: Seconds 127, cycle number 7999 and offset 3071 with a tick give an all-zero word, and no other output reacts.
- R6: When `load_en` is high, the word after the edge equals `load_word`, whatever `tick_en` is.
- R7: A loaded offset of 3072 or more becomes 0, and a loaded cycle number of 8000 or more becomes 0. The other fields keep their loaded values.
- R8: When `rd_en` is high, `rd_word` takes the value `time_word` had just before that edge. While `rd_en` is low, `rd_word` and `rd_ticks` hold.
- R9: `rd_ticks` equals offset + 3072 x cycle + 24576000 x seconds of the captured word, taken modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One 24.576 MHz time-base tick |
| load_en | input | 1 | Synchronous load of the whole word |
| load_word | input | 32 | Value to load |
| rd_en | input | 1 | Snapshot strobe |
| time_word | output | 32 | Live cycle time word |
| rd_word | output | 32 | Captured word |
| rd_ticks | output | 32 | Linear tick count of the captured word |

## Verification
The bench builds the block with its default field widths and moduli: 12-bit offset modulo 3072, 13-bit cycle number modulo 8000 and 7-bit seconds. With these values the bit positions match the stated word layout. A second wrap or a seconds rollover needs millions of ticks by counting alone. The bench reaches them in a single clock by loading values just below each boundary. The same loads drive out-of-range fields to exercise the clamp, and a snapshot taken at the largest word exercises the linear conversion near its top.

// File: rtl/ctime_pkg.sv
package ctime_pkg;
  localparam int CT_OFF_W   = 12;
  localparam int CT_CNT_W   = 13;
  localparam int CT_SEC_W   = 7;
  localparam int CT_OFF_MOD = 3072;
  localparam int CT_CNT_MOD = 8000;
  localparam int CT_TICK_W  = 32;
endpackage

// File: rtl/ctime_field.sv
module ctime_field #(
  parameter int W   = 12,
  parameter int MOD = 3072
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] val,
  output logic         wrap
);
  localparam bit         FULL = (MOD == (1 << W));
  localparam logic [W:0] LIM  = (W+1)'(MOD);
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic [W-1:0] ld_fix;

  generate
    if (FULL) begin : g_full
      assign ld_fix = ld_val;
    end else begin : g_clamp
      assign ld_fix = ({1'b0, ld_val} >= LIM) ? '0 : ld_val;
    end
  endgenerate

  assign wrap = inc && (val == TOP);

  always_ff @(posedge clk) begin
    if (rst) val <= '0;
    else if (ld) val <= ld_fix;
    else if (inc) val <= (val == TOP) ? '0 : val + 1'b1;
  end
endmodule

// File: rtl/ctime_linear.sv
module ctime_linear #(
  parameter int OFF_W   = 12,
  parameter int CNT_W   = 13,
  parameter int SEC_W   = 7,
  parameter int OFF_MOD = 3072,
  parameter int CNT_MOD = 8000,
  parameter int TICK_W  = 32
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [SEC_W-1:0]  sec,
  output logic [TICK_W-1:0] ticks
);
  localparam logic [TICK_W-1:0] K_CYC = TICK_W'(OFF_MOD);
  localparam logic [TICK_W-1:0] K_SEC = TICK_W'(longint'(OFF_MOD) * longint'(CNT_MOD));

  logic [TICK_W-1:0] t_off, t_cyc, t_sec;

  always_comb begin
    t_off = TICK_W'(off);
    t_cyc = TICK_W'(cnt) * K_CYC;
    t_sec = TICK_W'(sec) * K_SEC;
    ticks = t_off + t_cyc + t_sec;
  end
endmodule

// File: rtl/ctime_counter.sv
module ctime_counter
  import ctime_pkg::*;
#(
  parameter int OFF_W   = CT_OFF_W,
  parameter int CNT_W   = CT_CNT_W,
  parameter int SEC_W   = CT_SEC_W,
  parameter int OFF_MOD = CT_OFF_MOD,
  parameter int CNT_MOD = CT_CNT_MOD,
  parameter int TICK_W  = CT_TICK_W,
  localparam int WORD_W = OFF_W + CNT_W + SEC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] time_word,
  output logic [WORD_W-1:0] rd_word,
  output logic [TICK_W-1:0] rd_ticks
);
  localparam int CNT_LO = OFF_W;
  localparam int SEC_LO = OFF_W + CNT_W;

  logic [OFF_W-1:0]  off_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SEC_W-1:0]  sec_q;
  logic              off_wrap, cnt_wrap, sec_wrap;
  logic [TICK_W-1:0] lin;

  ctime_field #(.W(OFF_W), .MOD(OFF_MOD)) u_off (
    .clk(clk), .rst(rst), .inc(tick_en), .ld(load_en),
    .ld_val(load_word[OFF_W-1:0]), .val(off_q), .wrap(off_wrap));

  ctime_field #(.W(CNT_W), .MOD(CNT_MOD)) u_cnt (
    .clk(clk), .rst(rst), .inc(off_wrap), .ld(load_en),
    .ld_val(load_word[SEC_LO-1:CNT_LO]), .val(cnt_q), .wrap(cnt_wrap));

  ctime_field #(.W(SEC_W), .MOD(1 << SEC_W)) u_sec (
    .clk(clk), .rst(rst), .inc(cnt_wrap), .ld(load_en),
    .ld_val(load_word[WORD_W-1:SEC_LO]), .val(sec_q), .wrap(sec_wrap));

  ctime_linear #(
    .OFF_W(OFF_W), .CNT_W(CNT_W), .SEC_W(SEC_W),
    .OFF_MOD(OFF_MOD), .CNT_MOD(CNT_MOD), .TICK_W(TICK_W)
  ) u_lin (.off(off_q), .cnt(cnt_q), .sec(sec_q), .ticks(lin));

  assign time_word = {sec_q, cnt_q, off_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_word  <= '0;
      rd_ticks <= '0;
    end else if (rd_en) begin
      rd_word  <= time_word;
      rd_ticks <= lin;
    end
  end
endmodule

// File: rtl/ctime_counter_chk.sv
module ctime_counter_chk #(
  parameter int OFF_W   = 12,
  parameter int CNT_W   = 13,
  parameter int SEC_W   = 7,
  parameter int OFF_MOD = 3072,
  parameter int CNT_MOD = 8000,
  parameter int TICK_W  = 32,
  localparam int WORD_W = OFF_W + CNT_W + SEC_W
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              load_en,
  input logic [WORD_W-1:0] load_word,
  input logic              rd_en,
  input logic [WORD_W-1:0] time_word,
  input logic [WORD_W-1:0] rd_word,
  input logic [TICK_W-1:0] rd_ticks
);
  localparam int CNT_LO = OFF_W;
  localparam int SEC_LO = OFF_W + CNT_W;

  logic [OFF_W-1:0] w_off;
  logic [CNT_W-1:0] w_cnt;
  assign w_off = time_word[OFF_W-1:0];
  assign w_cnt = time_word[SEC_LO-1:CNT_LO];

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !load_en) |=> $stable(time_word));

  a_r3_offset_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !load_en && w_off == OFF_W'(OFF_MOD - 1)) |=> (w_off == '0));

  a_r4_count_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !load_en && w_off == OFF_W'(OFF_MOD - 1) && w_cnt == CNT_W'(CNT_MOD - 1))
    |=> (w_cnt == '0));

  a_r6_load_wins: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (time_word[WORD_W-1:SEC_LO] == $past(load_word[WORD_W-1:SEC_LO])));

  a_r7_in_range: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) |-> ({1'b0, w_off} < (OFF_W+1)'(OFF_MOD) &&
                      {1'b0, w_cnt} < (CNT_W+1)'(CNT_MOD))));

  a_r8_snapshot_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ($stable(rd_word) && $stable(rd_ticks)));

  a_r8_snapshot_take: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_word == $past(time_word)));
endmodule

bind ctime_counter ctime_counter_chk #(
  .OFF_W(OFF_W), .CNT_W(CNT_W), .SEC_W(SEC_W),
  .OFF_MOD(OFF_MOD), .CNT_MOD(CNT_MOD), .TICK_W(TICK_W)
) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .load_en(load_en),
  .load_word(load_word), .rd_en(rd_en), .time_word(time_word),
  .rd_word(rd_word), .rd_ticks(rd_ticks));

// File: tb/ctime_counter_test.sv
module ctime_counter_test;
  localparam int CLK_NS = 5;
  localparam int NV = 12;

  // {load_en, tick_en, load_word, expected time_word}
  localparam logic [65:0] VEC [NV] = '{
    {1'b1, 1'b1, 32'h0000_0BFE, 32'h0000_0BFE},  // R6 load beats tick
    {1'b0, 1'b1, 32'h0,         32'h0000_0BFF},  // R2 advance
    {1'b0, 1'b1, 32'h0,         32'h0000_1000},  // R3 offset wrap
    {1'b0, 1'b0, 32'h0,         32'h0000_1000},  // R2 idle hold
    {1'b1, 1'b0, 32'h0BF3_FBFF, 32'h0BF3_FBFF},  // R6 load
    {1'b0, 1'b1, 32'h0,         32'h0C00_0000},  // R4 count wrap
    {1'b1, 1'b0, 32'hFFF3_FBFF, 32'hFFF3_FBFF},  // R6 load top
    {1'b0, 1'b1, 32'h0,         32'h0000_0000},  // R5 seconds wrap
    {1'b1, 1'b0, 32'h0200_5FFF, 32'h0200_5000},  // R7 offset clamp
    {1'b1, 1'b0, 32'h05FF_F007, 32'h0400_0007},  // R7 count clamp
    {1'b0, 1'b1, 32'h0,         32'h0400_0008},  // R2 advance
    {1'b1, 1'b1, 32'h0000_0010, 32'h0000_0010}   // R6 load beats tick
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        load_en = 1'b0;
  logic [31:0] load_word = '0;
  logic        rd_en = 1'b0;
  logic [31:0] time_word, rd_word, rd_ticks;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  ctime_counter uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .load_en(load_en),
    .load_word(load_word), .rd_en(rd_en), .time_word(time_word),
    .rd_word(rd_word), .rd_ticks(rd_ticks));

  always #(CLK_NS / 2.0) clk = ~clk;

  function automatic logic [31:0] lin_of(input logic [31:0] w);
    longint t;
    t = longint'(w[11:0]) + 64'd3072 * longint'(w[24:12]) + 64'd24576000 * longint'(w[31:25]);
    return t[31:0];
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic drive(input logic ld, input logic tk, input logic rd, input logic [31:0] w);
    load_en = ld; tick_en = tk; rd_en = rd; load_word = w;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap;
    cyc(); cyc();
    check("R1 word", time_word, 32'h0);
    check("R1 rd_word", rd_word, 32'h0);
    check("R1 rd_ticks", rd_ticks, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][65], VEC[i][64], 1'b0, VEC[i][63:32]);
      cyc();
      check($sformatf("vector %0d (R2-R7 table)", i), time_word, VEC[i][31:0]);
    end
    drive(1'b0, 1'b0, 1'b0, '0);

    // R2: ten ticks from zero
    drive(1'b1, 1'b0, 1'b0, 32'h0); cyc();
    drive(1'b0, 1'b1, 1'b0, '0);
    for (int k = 0; k < 10; k++) cyc();
    check("R2 ten ticks", time_word, 32'h0000_000A);

    // R8/R9: snapshot taken together with a tick
    drive(1'b1, 1'b0, 1'b0, 32'h0BF3_FBFF); cyc();
    drive(1'b0, 1'b1, 1'b1, '0); cyc();
    check("R8 captured word", rd_word, 32'h0BF3_FBFF);
    check("R8 live moved on", time_word, 32'h0C00_0000);
    check("R9 linear", rd_ticks, lin_of(32'h0BF3_FBFF));

    // R8: hold while rd_en low
    drive(1'b0, 1'b1, 1'b0, '0);
    cyc(); cyc(); cyc();
    check("R8 hold word", rd_word, 32'h0BF3_FBFF);
    check("R8 hold ticks", rd_ticks, lin_of(32'h0BF3_FBFF));

    // R9: largest legal word
    drive(1'b1, 1'b0, 1'b0, 32'hFFF3_FBFF); cyc();
    drive(1'b0, 1'b0, 1'b1, '0); cyc();
    check("R9 top linear", rd_ticks, 32'd3145727999);

    // R5: rollover leaves snapshot untouched
    drive(1'b0, 1'b1, 1'b0, '0); cyc();
    check("R5 rollover word", time_word, 32'h0);
    check("R5 snapshot unaffected", rd_word, 32'hFFF3_FBFF);

    // R9: small value
    snap = 32'h0200_3005;
    drive(1'b1, 1'b0, 1'b0, snap); cyc();
    drive(1'b0, 1'b0, 1'b1, '0); cyc();
    check("R9 small linear", rd_ticks, 32'd24576000 + 32'd3 * 32'd3072 + 32'd5);

    // R1: reset mid-run
    drive(1'b0, 1'b1, 1'b0, '0);
    rst = 1'b1; cyc();
    check("R1 mid-run word", time_word, 32'h0);
    check("R1 mid-run rd_word", rd_word, 32'h0);
    check("R1 mid-run rd_ticks", rd_ticks, 32'h0);
    rst = 1'b0;
    drive(1'b0, 1'b0, 1'b0, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule